// File: doc/BRIEF.md
# Paper Tape Word Assembler

This block takes one decoded paper-tape character per cycle and builds the contents of a 116-bit input buffer. The buffer holds four consecutive 29-bit words. A block-end character hands the whole buffer to a four-word destination store in one transfer.

The block accepts two tape formats, and both may appear in the same block.

- **Raw format.** A block is a run of 29 hex digits followed by a reload or stop character. The digits fill all 116 bits.
- **Signed format.** Each word is written as an optional minus or blank sign character, then seven hex digits for a 28-bit magnitude, then a tab or carriage return. The sign is held in a flip-flop and is only shifted into the buffer when the tab or carriage return arrives. A stop character also raises a request to halt the reader. That request is held until it is acknowledged.

Top module: `ptape_word_asm`

## Requirements
- R1: While reset is high, and on the first cycle after it, `xfer_valid` and `stop_req` are 0. A reload sent straight after reset transfers all zeros.
- R2: A digit code has bit 4 = 0, and its value is bits 3:0. Values 10 to 15 are the letter keys u, v, w, x, y and z. Each digit shifts the buffer left by 4 bits and places the new value in bits 3:0.
- R3: After 29 digits, the first digit occupies bits 115:112. Any digit beyond 29 pushes the oldest digit out of the top of the buffer.
- R4: A reload (code 0x14) makes `xfer_valid` high for exactly the one cycle after the character is accepted. During that cycle `xfer_data` equals the buffer contents.
- R5: A stop (code 0x15) causes the same transfer as a reload. It also raises `stop_req` in the same cycle as `xfer_valid`. `stop_req` then stays high until `stop_ack` is asserted.
- R6: Minus (code 0x10) sets the sign flip-flop. Tab (code 0x12) shifts the buffer left by 1 bit, puts the sign in bit 0, and clears the sign.
- R7: Blank (code 0x11) changes neither the buffer nor the sign flip-flop. A blank between a minus and a tab leaves the sign set.
- R8: Carriage return (code 0x13) behaves exactly like tab.
- R9: A minus that is never followed by a tab or carriage return is never shifted into the buffer. The next reload or stop clears it.
- R10: The buffer and the sign flip-flop are empty again on the cycle after a transfer. A character accepted in that cycle acts on the emptied buffer.
- R11: Codes 0x16 to 0x1F change nothing.
- R12: Four signed-format words give a buffer laid out as {mag0, s0, mag1, s1, mag2, s2, mag3, s3}, with the first word in the top 29 bits.
- R13: `stop_ack` clears `stop_req` on the next cycle. If a stop arrives in the same cycle as the acknowledge, the stop wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chr_vld | input | 1 | A character code is present this cycle |
| chr_code | input | 5 | Decoded tape character code |
| stop_ack | input | 1 | Acknowledge that clears the halt request |
| xfer_valid | output | 1 | One-cycle transfer strobe |
| xfer_data | output | 116 | Buffer image, valid while `xfer_valid` is high |
| stop_req | output | 1 | Request to halt the tape reader |

## Verification
Internal state is only visible at the ports through a transfer. A corrupted buffer bit or a sign flip-flop stuck in the wrong state shows up as a wrong `xfer_data` value on the next reload or stop strobe, and no earlier. A mis-shifted digit or sign moves every later field by its shift width, so one bad step corrupts the rest of the block. Faults in the hold and acknowledge logic of the halt request show up on `stop_req` within one cycle.

// File: rtl/ptape_pkg.sv
package ptape_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned NUM_FN  = 6;
  // low-nibble selectors of function codes (upper code bits == 1)
  localparam int unsigned FN_MINUS  = 0;
  localparam int unsigned FN_BLANK  = 1;
  localparam int unsigned FN_TAB    = 2;
  localparam int unsigned FN_CR     = 3;
  localparam int unsigned FN_RELOAD = 4;
  localparam int unsigned FN_STOP   = 5;

  typedef struct packed {
    logic digit;  // hex digit
    logic minus;  // set sign
    logic blank;  // no-op sign slot
    logic brk;    // tab or carriage return: insert sign
    logic xfer;   // reload or stop: transfer buffer
    logic halt;   // stop only
  } cls_t;
endpackage

// File: rtl/ptape_char_decode.sv
module ptape_char_decode
  import ptape_pkg::*;
#(
  parameter int unsigned CODE_W = 5
) (
  input  logic              vld,
  input  logic [CODE_W-1:0] code,
  output cls_t              cls,
  output logic [DIGIT_W-1:0] nib
);
  localparam int unsigned HI_W = CODE_W - DIGIT_W;

  logic [HI_W-1:0]    hi;
  logic [DIGIT_W-1:0] lo;
  logic [NUM_FN-1:0]  fn_hit;

  assign hi  = code[CODE_W-1:DIGIT_W];
  assign lo  = code[DIGIT_W-1:0];
  assign nib = lo;

  for (genvar k = 0; k < NUM_FN; k++) begin : g_fn
    assign fn_hit[k] = vld && (hi == HI_W'(1)) && (lo == DIGIT_W'(k));
  end

  always_comb begin
    cls.digit = vld && (hi == '0);
    cls.minus = fn_hit[FN_MINUS];
    cls.blank = fn_hit[FN_BLANK];
    cls.brk   = fn_hit[FN_TAB] | fn_hit[FN_CR];
    cls.xfer  = fn_hit[FN_RELOAD] | fn_hit[FN_STOP];
    cls.halt  = fn_hit[FN_STOP];
  end
endmodule

// File: rtl/ptape_asm_buf.sv
module ptape_asm_buf
  import ptape_pkg::*;
#(
  parameter int unsigned BUF_W = 116
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  cls_t               cls,
  input  logic [DIGIT_W-1:0] nib,
  output logic [BUF_W-1:0]   acc_eff,
  output logic               sign_q
);
  logic [BUF_W-1:0] acc_q, acc_d;
  logic             sign_eff, sign_d;

  // a pending clear applies before the current character
  always_comb begin
    acc_eff  = clr ? '0 : acc_q;
    sign_eff = clr ? 1'b0 : sign_q;
    acc_d    = acc_eff;
    sign_d   = sign_eff;
    if (cls.digit) begin
      acc_d = {acc_eff[BUF_W-DIGIT_W-1:0], nib};
    end else if (cls.brk) begin
      acc_d  = {acc_eff[BUF_W-2:0], sign_eff};
      sign_d = 1'b0;
    end else if (cls.minus) begin
      sign_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      sign_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      sign_q <= sign_d;
    end
  end

  AST_MINUS_SETS_SIGN: assert property (@(posedge clk) disable iff (rst)
    cls.minus |=> sign_q); // R6
  AST_BREAK_CLEARS_SIGN: assert property (@(posedge clk) disable iff (rst)
    cls.brk |=> !sign_q); // R6
  AST_BLANK_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (cls.blank && !clr) |=> ($stable(acc_q) && $stable(sign_q))); // R7
  AST_EMPTY_AFTER_XFER: assert property (@(posedge clk) disable iff (rst)
    (clr && !cls.digit && !cls.brk) |=> (acc_q == '0)); // R10
endmodule

// File: rtl/ptape_xfer_ctl.sv
module ptape_xfer_ctl
  import ptape_pkg::*;
#(
  parameter int unsigned BUF_W = 116
) (
  input  logic             clk,
  input  logic             rst,
  input  cls_t             cls,
  input  logic             stop_ack,
  input  logic [BUF_W-1:0] acc_eff,
  output logic             xfer_valid,
  output logic [BUF_W-1:0] xfer_data,
  output logic             stop_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_valid <= 1'b0;
      xfer_data  <= '0;
      stop_req   <= 1'b0;
    end else begin
      xfer_valid <= cls.xfer;
      if (cls.xfer) xfer_data <= acc_eff;
      if (cls.halt)      stop_req <= 1'b1;
      else if (stop_ack) stop_req <= 1'b0;
    end
  end

  AST_XFER_FROM_END_CHAR: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> $past(cls.xfer)); // R4
  AST_STOP_WITH_XFER: assert property (@(posedge clk) disable iff (rst)
    cls.halt |=> (stop_req && xfer_valid)); // R5
  AST_STOP_HELD: assert property (@(posedge clk) disable iff (rst)
    (stop_req && !stop_ack) |=> stop_req); // R5
  AST_ACK_CLEARS_STOP: assert property (@(posedge clk) disable iff (rst)
    (stop_ack && !cls.halt) |=> !stop_req); // R13
endmodule

// File: rtl/ptape_word_asm.sv
module ptape_word_asm
  import ptape_pkg::*;
#(
  parameter int unsigned WORD_W = 29,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned CODE_W = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      chr_vld,
  input  logic [CODE_W-1:0]         chr_code,
  input  logic                      stop_ack,
  output logic                      xfer_valid,
  output logic [WORD_W*WORDS-1:0]   xfer_data,
  output logic                      stop_req
);
  localparam int unsigned BUF_W = WORD_W * WORDS;

  cls_t               cls;
  logic [DIGIT_W-1:0] nib;
  logic [BUF_W-1:0]   acc_eff;
  logic               sign_q;

  ptape_char_decode #(.CODE_W(CODE_W)) u_dec (
    .vld  (chr_vld),
    .code (chr_code),
    .cls  (cls),
    .nib  (nib)
  );

  ptape_asm_buf #(.BUF_W(BUF_W)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .clr     (xfer_valid),
    .cls     (cls),
    .nib     (nib),
    .acc_eff (acc_eff),
    .sign_q  (sign_q)
  );

  ptape_xfer_ctl #(.BUF_W(BUF_W)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .cls        (cls),
    .stop_ack   (stop_ack),
    .acc_eff    (acc_eff),
    .xfer_valid (xfer_valid),
    .xfer_data  (xfer_data),
    .stop_req   (stop_req)
  );

  AST_SIGN_CLEAR_AFTER_XFER: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !(chr_vld && chr_code == CODE_W'(16))) |=> !sign_q); // R9
endmodule

// File: tb/ptape_word_asm_test.sv
module ptape_word_asm_test;
  localparam int BW = 116;
  localparam logic [4:0] C_MINUS = 5'h10, C_BLANK = 5'h11, C_TAB = 5'h12,
                         C_CR = 5'h13, C_RELOAD = 5'h14, C_STOP = 5'h15;

  logic clk = 0, rst = 1, chr_vld = 0, stop_ack = 0;
  logic [4:0] chr_code = '0;
  logic xfer_valid, stop_req;
  logic [BW-1:0] xfer_data;

  always #5 clk = ~clk;

  ptape_word_asm uut (
    .clk(clk), .rst(rst), .chr_vld(chr_vld), .chr_code(chr_code),
    .stop_ack(stop_ack), .xfer_valid(xfer_valid), .xfer_data(xfer_data),
    .stop_req(stop_req)
  );

  typedef struct { logic [BW-1:0] d; logic stp; string tag; } exp_t;
  exp_t sbq[$];
  int vecs = 0, miss = 0;
  string cur_tag = "R1";
  logic [BW-1:0] m_acc = '0;
  logic m_sign = 0;

  task automatic chk(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one character per cycle, model updated from the requirements
  task automatic put(input logic [4:0] c);
    chr_vld = 1; chr_code = c;
    if (c[4] == 0) m_acc = {m_acc[BW-5:0], c[3:0]};
    else if (c == C_MINUS) m_sign = 1;
    else if (c == C_TAB || c == C_CR) begin m_acc = {m_acc[BW-2:0], m_sign}; m_sign = 0; end
    else if (c == C_RELOAD || c == C_STOP) begin
      sbq.push_back('{m_acc, (c == C_STOP), cur_tag});
      m_acc = '0; m_sign = 0;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    chr_vld = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic hex_word(input logic [27:0] v);
    for (int i = 6; i >= 0; i--) put({1'b0, v[i*4 +: 4]});
  endtask

  // monitor: compare every transfer against the scoreboard
  always @(negedge clk) begin
    if (!rst && xfer_valid) begin
      if (sbq.size() == 0) begin
        vecs++; miss++;
        $display("FAIL %s unexpected transfer actual=%h expected=none", cur_tag, xfer_data);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(e.tag, xfer_data, e.d);
        if (e.stp) chk({e.tag, " R5 stop_req"}, BW'(stop_req), BW'(1));
      end
    end
  end

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    vecs++; miss++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 xfer_valid in reset", BW'(xfer_valid), '0);
    chk("R1 stop_req in reset", BW'(stop_req), '0);
    rst = 0;
    chk("R1 xfer_valid after reset", BW'(xfer_valid), '0);
    chk("R1 stop_req after reset", BW'(stop_req), '0);
    cur_tag = "R1"; put(C_RELOAD); idle(2);

    // raw format with all letter digits, R2/R3/R4
    cur_tag = "R2 R3 R4 raw block";
    for (int i = 0; i < 29; i++) put(5'((i * 7 + 3) % 16));
    put(C_RELOAD); idle(1);
    chk("R4 strobe one cycle", BW'(xfer_valid), '0);
    idle(1);

    // overflow drops oldest digits, R3
    cur_tag = "R3 overflow";
    for (int i = 0; i < 31; i++) put(5'((i * 5 + 11) % 16));
    put(C_RELOAD); idle(2);

    // signed format: tab and CR mixed, R6 R8 R12
    cur_tag = "R6 R8 R12 signed words";
    put(C_MINUS); hex_word(28'h1234567); put(C_TAB);
    put(C_BLANK); hex_word(28'hABCDEF0); put(C_CR);
    hex_word(28'h0000009); put(C_TAB);
    put(C_MINUS); hex_word(28'hFFFFFFF); put(C_CR);
    chk("R12 layout", m_acc, {28'h1234567, 1'b1, 28'hABCDEF0, 1'b0, 28'h0000009, 1'b0, 28'hFFFFFFF, 1'b1});
    put(C_RELOAD); idle(2);

    // blank leaves sign and buffer unchanged, R7
    cur_tag = "R7 blank";
    put(5'h3); put(C_MINUS); put(C_BLANK); put(C_BLANK); put(C_TAB); put(C_BLANK);
    put(C_RELOAD); idle(2);

    // unknown codes ignored, R11
    cur_tag = "R11 unknown codes";
    put(5'h9);
    for (int c = 22; c < 32; c++) put(5'(c));
    put(5'h4); put(C_MINUS);
    for (int c = 22; c < 32; c++) put(5'(c));
    put(C_CR); put(C_RELOAD); idle(2);

    // dangling minus, R9
    cur_tag = "R9 dangling minus";
    put(C_MINUS); hex_word(28'h7654321); put(C_RELOAD); idle(1);
    cur_tag = "R9 sign cleared by reload";
    put(C_TAB); put(C_RELOAD); idle(2);

    // back-to-back and char right after transfer, R10
    cur_tag = "R10 back-to-back";
    put(5'hE); put(C_RELOAD); put(C_RELOAD); put(5'h5); put(C_RELOAD); idle(2);
    cur_tag = "R10 minus after reload";
    put(C_MINUS); put(C_RELOAD); put(C_TAB); put(C_RELOAD); idle(2);

    // stop and acknowledge, R5 R13
    cur_tag = "R5 stop";
    put(5'hA); put(C_STOP); chr_vld = 0;
    chk("R5 stop_req raised", BW'(stop_req), BW'(1));
    idle(5);
    chk("R5 stop_req held", BW'(stop_req), BW'(1));
    stop_ack = 1; @(negedge clk); stop_ack = 0;
    chk("R13 ack clears", BW'(stop_req), '0);
    cur_tag = "R13 stop with ack";
    stop_ack = 1; put(C_STOP); stop_ack = 0; chr_vld = 0;
    chk("R13 stop wins over ack", BW'(stop_req), BW'(1));
    stop_ack = 1; @(negedge clk); stop_ack = 0;
    chk("R13 ack clears again", BW'(stop_req), '0);
    idle(3);

    chk("R4 all transfers seen", BW'(sbq.size()), '0);
    summary();
  end
endmodule